// File: doc/BRIEF.md
# Dual-Port GPIO Register Bank

This block keeps the per-bit state of two byte-wide general purpose I/O ports. Each port has three stored registers: a drive-value register, an inversion register and a direction register. The bank also has a read path that returns the synchronised pin levels. For every pin it presents a drive value and a driver enable to the pad ring, and it takes the raw pin levels back through a two-flop synchroniser.

Software-side access uses a plain strobe interface. A write strobe with a 3-bit register index loads one byte. The read data is a combinational function of the read index and the current state. The register index is decoded as follows: bit 0 selects the port, and bits 2:1 select the register kind (00 pin level, 01 drive value, 10 inversion, 11 direction). Index 0 is therefore the port 0 pin level and index 7 is the port 1 direction.

Top module: `gpio_bank`

## Requirements
- R1: After reset, both direction registers read 0xFF, both drive-value registers read 0xFF, both inversion registers read 0x00, and every pad enable is 0.
- R2: Register index decode is as follows: bit 0 selects the port (0 or 1), and bits 2:1 select the kind (00 pin level, 01 drive value, 10 inversion, 11 direction). A read returns the selected byte in the same cycle.
- R3: A write with `wr_en` high loads `wr_data` into the addressed byte on the next clock edge and leaves the other five stored bytes unchanged.
- R4: A write to index 0 or 1 (pin level) has no effect on any stored register or on any output.
- R5: A direction bit of 1 makes the pin an input with its driver off (`pad_oe` bit 0). A direction bit of 0 enables the driver (`pad_oe` bit 1). In both cases `pad_out` equals the stored drive-value bit.
- R6: A pin-level read returns the pin sampled through two flops, XOR the inversion bit. The level appears in the read data two clock edges after it is applied at `pad_in`, whatever the direction of the pin.
- R7: A drive-value read returns the stored flop contents, not the pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 3 | Write register index |
| wr_data | input | 8 | Write data byte |
| rd_idx | input | 3 | Read register index |
| rd_data | output | 8 | Read data byte |
| pad_in | input | 16 | Raw pin levels, port 1 in the upper byte |
| pad_out | output | 16 | Per-pin drive value |
| pad_oe | output | 16 | Per-pin driver enable |

## Verification
Every index is written with a distinct byte and then all eight indices are read back. This separates a wrong decode or a write into a neighbouring register from a correct independent store. Pin-level reads sweep every value of one port byte against every inversion value taken from a small set (0x00, 0xFF, 0xA5, 0x3C). The XOR is thereby tested for bit-order mistakes, and a pin level driven against an opposite stored drive value shows that the drive-value read never returns the pin. Direction patterns of walking ones and zeros confirm that the enable is the per-bit complement of the direction and that the two ports do not swap.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_W  = 8;
  localparam int NPORTS  = 2;
  localparam int IDX_W   = 3;
  localparam int PIN_W   = PORT_W * NPORTS;

  typedef enum logic [1:0] {
    KIND_LEVEL = 2'b00,
    KIND_DRIVE = 2'b01,
    KIND_INV   = 2'b10,
    KIND_DIR   = 2'b11
  } reg_kind_e;

  function automatic reg_kind_e kind_of(input logic [IDX_W-1:0] idx);
    return reg_kind_e'(idx[2:1]);
  endfunction

  function automatic logic port_of(input logic [IDX_W-1:0] idx);
    return idx[0];
  endfunction

  function automatic logic [PORT_W-1:0] level_view(input logic [PORT_W-1:0] lvl,
                                                   input logic [PORT_W-1:0] inv);
    return lvl ^ inv;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

  assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> q == $past(d, 2));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_drive,
  input  logic         wr_inv,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] level_sync,
  output logic [W-1:0] drive_q,
  output logic [W-1:0] inv_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] level_rd,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '1;
      inv_q   <= '0;
      dir_q   <= '1;
    end else begin
      if (wr_drive) drive_q <= wdata;
      if (wr_inv)   inv_q   <= wdata;
      if (wr_dir)   dir_q   <= wdata;
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign pin_oe[b]   = ~dir_q[b];
    assign pin_out[b]  = drive_q[b];
    assign level_rd[b] = level_sync[b] ^ inv_q[b];
  end

  assert_hold_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_drive |=> $stable(drive_q));
  assert_hold_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_inv |=> $stable(inv_q));
  assert_hold_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));
  assert_load_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata));
  assert_oe_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & dir_q) == '0);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PORT_W-1:0] rd_data,
  input  logic [PIN_W-1:0]  pad_in,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  pad_oe
);
  logic [PIN_W-1:0] pins_sync;
  logic [PORT_W-1:0] drive_q [NPORTS];
  logic [PORT_W-1:0] inv_q   [NPORTS];
  logic [PORT_W-1:0] dir_q   [NPORTS];
  logic [PORT_W-1:0] lvl_rd  [NPORTS];
  logic wr_level_evt;

  assign wr_level_evt = wr_en && kind_of(wr_idx) == KIND_LEVEL;

  gpio_sync #(.W(PIN_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pins_sync)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic sel;
    assign sel = wr_en && (port_of(wr_idx) == p[0]);
    gpio_port #(.W(PORT_W)) u_port (
      .clk(clk), .rst_n(rst_n),
      .wr_drive(sel && kind_of(wr_idx) == KIND_DRIVE),
      .wr_inv  (sel && kind_of(wr_idx) == KIND_INV),
      .wr_dir  (sel && kind_of(wr_idx) == KIND_DIR),
      .wdata(wr_data),
      .level_sync(pins_sync[p*PORT_W +: PORT_W]),
      .drive_q(drive_q[p]), .inv_q(inv_q[p]), .dir_q(dir_q[p]),
      .level_rd(lvl_rd[p]),
      .pin_out(pad_out[p*PORT_W +: PORT_W]),
      .pin_oe(pad_oe[p*PORT_W +: PORT_W])
    );
  end

  always_comb begin
    logic pr;
    pr = port_of(rd_idx);
    unique case (kind_of(rd_idx))
      KIND_LEVEL: rd_data = lvl_rd[pr];
      KIND_DRIVE: rd_data = drive_q[pr];
      KIND_INV:   rd_data = inv_q[pr];
      default:    rd_data = dir_q[pr];
    endcase
  end

  assert_level_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_level_evt |=> $stable(pad_out) && $stable(pad_oe));
  assert_level_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kind_of(rd_idx) == KIND_LEVEL |->
      rd_data == level_view(pins_sync[port_of(rd_idx)*PORT_W +: PORT_W],
                            inv_q[port_of(rd_idx)]));
  assert_rst_dir_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> pad_oe == '0);
endmodule

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_idx = 0, rd_idx = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [15:0] pad_in = 0, pad_out, pad_oe;
  int n_run = 0, n_fail = 0;
  logic [7:0] inv_set [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};

  always #5 clk = ~clk;

  gpio_bank u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_idx = i; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [7:0] d);
    rd_idx = i; #1; d = rd_data;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] img [8];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    for (int i = 2; i < 8; i++) begin
      rd(i[2:0], v);
      chk("R1", {8'h0, v}, (i >= 6 || i < 4) ? 16'h00FF : 16'h0000);
    end
    chk("R1 oe", pad_oe, 16'h0000);
    chk("R1 out", pad_out, 16'hFFFF);

    // R2 R3: distinct bytes to each index
    for (int i = 2; i < 8; i++) begin
      img[i] = 8'h11 * i[7:0] + 8'h08;
      wr(i[2:0], img[i]);
    end
    for (int i = 2; i < 8; i++) begin
      rd(i[2:0], v);
      chk("R2 R3 readback", {8'h0, v}, {8'h0, img[i]});
    end
    chk("R5 out", pad_out, {img[3], img[2]});
    chk("R5 oe", pad_oe, ~{img[7], img[6]});

    // R4 writes to level indices are ignored
    wr(3'd0, 8'h5A); wr(3'd1, 8'hC3);
    for (int i = 2; i < 8; i++) begin
      rd(i[2:0], v);
      chk("R4 no effect", {8'h0, v}, {8'h0, img[i]});
    end
    chk("R4 out", pad_out, {img[3], img[2]});
    chk("R4 oe", pad_oe, ~{img[7], img[6]});

    // R5 walking direction
    for (int b = 0; b < 8; b++) begin
      wr(3'd6, ~(8'h1 << b)); wr(3'd7, 8'h1 << b);
      chk("R5 walk", pad_oe, {~(8'h1 << b), 8'h1 << b});
    end

    // R6 sweep port0 levels vs inversion set; R7 drive read is not pin
    wr(3'd2, 8'h00);
    for (int k = 0; k < 4; k++) begin
      wr(3'd4, inv_set[k]);
      for (int p = 0; p < 256; p++) begin
        @(negedge clk); pad_in = {8'h00, p[7:0]};
        @(negedge clk);
        rd(3'd0, v);
        if (p > 0) chk("R6 one edge early", {8'h0, v}, {8'h0, (p[7:0] - 8'd1) ^ inv_set[k]});
        @(negedge clk);
        rd(3'd0, v);
        chk("R6 level", {8'h0, v}, {8'h0, p[7:0] ^ inv_set[k]});
      end
    end
    pad_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    rd(3'd2, v); chk("R7 drive not pin", {8'h0, v}, 16'h0000);
    wr(3'd5, 8'h0F);
    rd(3'd1, v); chk("R6 port1", {8'h0, v}, 16'h00F0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule